// File: doc/BRIEF.md
# Wear-Levelling Erase-Block Allocator

This block owns the placement of logical blocks onto a small pool of physical NAND erase blocks inside a flash controller. For every physical block it holds an erase count, a bad flag and a state (erased, in use or stale). It also holds a table that maps each logical block to the physical block that carries its data. A write request for a logical block makes the block scan the whole pool once, at one block per clock. It picks a target, moves the mapping over and marks the block that held the old data as stale. It answers with the chosen physical block and a flag that says whether an erase must be issued before programming. A read request returns the current mapping.

Two mode pins choose the policy. `wl_static` picks the wear-levelling rule. When it is low, only erased blocks are eligible. When it is high, stale blocks are eligible as well, and the rule is the lowest erase count over all of them. `bb_reserve` picks the bad-block rule. When it is low, bad blocks are passed over in a single pool. When it is high, the highest-numbered blocks form a spare pool that is used only when the main pool has nothing eligible. The controller can flag a block as bad at any idle moment, for example after a failed program.

Both request and response use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response has been taken. The response holds `rsp_valid` and all of its fields steady while `rsp_ready` is low, so the consumer may stall it for any number of cycles.

Top module: `flash_wl_alloc`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. No logical block is mapped, all blocks are erased and good, and all erase counts are zero.
- R2: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays 0 until the response has been taken. While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields do not change.
- R3: A read response is valid right after the accepting edge. A write response becomes valid NUM_PHYS+1 edges after the accepting edge, because the scan visits one block per cycle.
- R4: A read (`req_write`=0) returns the mapped physical block with `rsp_err`=0 and `rsp_erase`=0. If the logical block is unmapped, it returns `rsp_err`=1 and `rsp_pba`=0.
- R5: With `wl_static`=0, the target is the good, erased, eligible block with the lowest erase count. Ties go to the lowest index. `rsp_erase` is 0.
- R6: With `wl_static`=1, the target is the good block that is not in use (erased or stale) with the lowest erase count. Ties go to the lowest index. `rsp_erase` is 1 exactly when that block is stale.
- R7: A block's erase count rises by one each time a write that targets it reports `rsp_erase`=1. The count stays at 2^CNT_W-1 once it reaches that value and never changes otherwise.
- R8: On a rewrite, the physical block that previously held the logical block becomes stale and is not erased. A stale block is never chosen with `wl_static`=0.
- R9: A pulse on `mark_bad` flags `mark_pba` as bad for good. That block is never returned by any later write.
- R10: With `bb_reserve`=0, all NUM_PHYS blocks form one pool and bad ones are passed over.
- R11: With `bb_reserve`=1, blocks NUM_PHYS-NUM_RSV and up are spares. A spare is chosen only if no main-pool block is eligible, and then it is the lowest-indexed good, erased spare.
- R12: If no block is eligible, the write answers `rsp_err`=1, `rsp_erase`=0 and `rsp_pba`=0, and the mapping stays as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wl_static | input | 1 | 1 = static wear levelling, 0 = dynamic |
| bb_reserve | input | 1 | 1 = spare-pool bad-block rule, 0 = skip rule |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_lba | input | $clog2(NUM_LOG) | Logical block of the request |
| req_write | input | 1 | 1 = allocate for write, 0 = look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_pba | output | $clog2(NUM_PHYS) | Chosen or mapped physical block |
| rsp_erase | output | 1 | Target must be erased before programming |
| rsp_err | output | 1 | No eligible block, or logical block unmapped |
| mark_bad | input | 1 | Flag one physical block as bad |
| mark_pba | input | $clog2(NUM_PHYS) | Block flagged by `mark_bad` |

## Verification
The assertions assume that `wl_static`, `bb_reserve` and `mark_bad` stay quiet while a write scan is running. Under that assumption, a committed target can be required to be good and, when no erase is requested, erased. They also assume that `req_lba` is below NUM_LOG. The bench changes the mode pins and pulses `mark_bad` only while `req_ready` is high and no response is pending. It uses only in-range logical addresses. The vector sequence drives the pool into exhaustion, stale reuse, spare fallback and tie-breaking states, so that each selection outcome can be computed by hand.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  typedef enum logic [1:0] {
    BLK_ERASED = 2'd0,
    BLK_USED   = 2'd1,
    BLK_STALE  = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SCAN   = 2'd1,
    S_COMMIT = 2'd2,
    S_RESP   = 2'd3
  } alloc_state_e;
endpackage

// File: rtl/fwl_table.sv
module fwl_table
  import fwl_pkg::*;
#(
  parameter int NUM_PHYS = 8,
  parameter int NUM_LOG  = 4,
  parameter int CNT_W    = 4,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int LW = $clog2(NUM_LOG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    scan_idx,
  output logic             scan_bad,
  output blk_state_e       scan_state,
  output logic [CNT_W-1:0] scan_cnt,
  input  logic [LW-1:0]    lkp_lba,
  output logic             lkp_valid,
  output logic [PW-1:0]    lkp_pba,
  input  logic             mark_en,
  input  logic [PW-1:0]    mark_pba,
  input  logic             commit_en,
  input  logic [LW-1:0]    commit_lba,
  input  logic [PW-1:0]    commit_pba,
  input  logic             commit_erase
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             bad   [NUM_PHYS];
  blk_state_e       st    [NUM_PHYS];
  logic [CNT_W-1:0] cnt   [NUM_PHYS];
  logic             map_v [NUM_LOG];
  logic [PW-1:0]    map_p [NUM_LOG];

  assign scan_bad   = bad[scan_idx];
  assign scan_state = st[scan_idx];
  assign scan_cnt   = cnt[scan_idx];
  assign lkp_valid  = map_v[lkp_lba];
  assign lkp_pba    = map_p[lkp_lba];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_PHYS; b++) begin
        bad[b] <= 1'b0;
        st[b]  <= BLK_ERASED;
        cnt[b] <= '0;
      end
      for (int l = 0; l < NUM_LOG; l++) begin
        map_v[l] <= 1'b0;
        map_p[l] <= '0;
      end
    end else begin
      if (mark_en) bad[mark_pba] <= 1'b1;
      if (commit_en) begin
        if (map_v[commit_lba]) st[map_p[commit_lba]] <= BLK_STALE;
        st[commit_pba]    <= BLK_USED;
        map_v[commit_lba] <= 1'b1;
        map_p[commit_lba] <= commit_pba;
        if (commit_erase && cnt[commit_pba] != CNT_MAX)
          cnt[commit_pba] <= cnt[commit_pba] + 1'b1;
      end
    end
  end

  // R9: a committed target is never a bad block
  assert_target_good_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> !bad[commit_pba]);

  // R5 / R6: a target that needs no erase must already be erased
  assert_no_erase_means_erased_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && !commit_erase) |-> st[commit_pba] == BLK_ERASED);

  for (genvar b = 0; b < NUM_PHYS; b++) begin : g_blk_chk
    // R7: a saturated count never wraps
    assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[b] == CNT_MAX |=> cnt[b] == CNT_MAX);
    // R7: a count changes only when an erase is issued for that block
    assert_cnt_only_on_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_en && commit_erase && commit_pba == PW'(b)) |=> $stable(cnt[b]));
    // R9: a bad flag is permanent
    assert_bad_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bad[b] |=> bad[b]);
  end
endmodule

// File: rtl/fwl_picker.sv
module fwl_picker
  import fwl_pkg::*;
#(
  parameter int NUM_PHYS = 8,
  parameter int NUM_RSV  = 2,
  parameter int CNT_W    = 4,
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int RBASE = NUM_PHYS - NUM_RSV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [PW-1:0]    idx,
  input  logic             wl_static,
  input  logic             bb_reserve,
  input  logic             c_bad,
  input  blk_state_e       c_state,
  input  logic [CNT_W-1:0] c_cnt,
  output logic             pick_found,
  output logic [PW-1:0]    pick_idx,
  output logic             pick_erase
);
  logic             best_found, best_stale, rsv_found;
  logic [PW-1:0]    best_idx, rsv_idx;
  logic [CNT_W-1:0] best_cnt;
  logic             in_rsv, prim_ok, better, rsv_ok;

  always_comb begin
    in_rsv  = bb_reserve && (int'(idx) >= RBASE);
    prim_ok = !c_bad && !in_rsv &&
              (wl_static ? (c_state != BLK_USED) : (c_state == BLK_ERASED));
    better  = !best_found || (c_cnt < best_cnt);
    rsv_ok  = in_rsv && !c_bad && (c_state == BLK_ERASED) && !rsv_found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      best_found <= 1'b0;
      best_stale <= 1'b0;
      best_idx   <= '0;
      best_cnt   <= '0;
      rsv_found  <= 1'b0;
      rsv_idx    <= '0;
    end else if (step) begin
      if (prim_ok && better) begin
        best_found <= 1'b1;
        best_idx   <= idx;
        best_cnt   <= c_cnt;
        best_stale <= (c_state == BLK_STALE);
      end
      if (rsv_ok) begin
        rsv_found <= 1'b1;
        rsv_idx   <= idx;
      end
    end
  end

  assign pick_found = best_found || rsv_found;
  assign pick_idx   = best_found ? best_idx : rsv_idx;
  assign pick_erase = best_found && best_stale;

  // R11: in spare mode the main-pool winner never lies in the spare range
  assert_main_pick_outside_spares_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (best_found && bb_reserve && !start) |-> int'(best_idx) < RBASE);
endmodule

// File: rtl/flash_wl_alloc.sv
module flash_wl_alloc
  import fwl_pkg::*;
#(
  parameter int NUM_PHYS = 8,
  parameter int NUM_LOG  = 4,
  parameter int CNT_W    = 4,
  parameter int NUM_RSV  = 2,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int LW = $clog2(NUM_LOG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wl_static,
  input  logic          bb_reserve,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [LW-1:0] req_lba,
  input  logic          req_write,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [PW-1:0] rsp_pba,
  output logic          rsp_erase,
  output logic          rsp_err,
  input  logic          mark_bad,
  input  logic [PW-1:0] mark_pba
);
  localparam logic [PW-1:0] LAST = PW'(NUM_PHYS - 1);

  alloc_state_e     state;
  logic [PW-1:0]    idx;
  logic [LW-1:0]    lba_q;
  logic             c_bad;
  blk_state_e       c_state;
  logic [CNT_W-1:0] c_cnt;
  logic             lkp_valid;
  logic [PW-1:0]    lkp_pba;
  logic             pick_found, pick_erase;
  logic [PW-1:0]    pick_idx;
  logic             start, commit_en;

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign start     = req_ready && req_valid && req_write;
  assign commit_en = (state == S_COMMIT) && pick_found;

  fwl_table #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .scan_idx(idx), .scan_bad(c_bad), .scan_state(c_state), .scan_cnt(c_cnt),
    .lkp_lba(req_lba), .lkp_valid(lkp_valid), .lkp_pba(lkp_pba),
    .mark_en(mark_bad), .mark_pba(mark_pba),
    .commit_en(commit_en), .commit_lba(lba_q), .commit_pba(pick_idx),
    .commit_erase(pick_erase)
  );

  fwl_picker #(.NUM_PHYS(NUM_PHYS), .NUM_RSV(NUM_RSV), .CNT_W(CNT_W)) u_picker (
    .clk(clk), .rst_n(rst_n), .start(start), .step(state == S_SCAN), .idx(idx),
    .wl_static(wl_static), .bb_reserve(bb_reserve),
    .c_bad(c_bad), .c_state(c_state), .c_cnt(c_cnt),
    .pick_found(pick_found), .pick_idx(pick_idx), .pick_erase(pick_erase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      lba_q     <= '0;
      rsp_pba   <= '0;
      rsp_erase <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          lba_q <= req_lba;
          idx   <= '0;
          if (req_write) begin
            state <= S_SCAN;
          end else begin
            rsp_pba   <= lkp_valid ? lkp_pba : '0;
            rsp_err   <= !lkp_valid;
            rsp_erase <= 1'b0;
            state     <= S_RESP;
          end
        end
        S_SCAN: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= S_COMMIT;
        end
        S_COMMIT: begin
          rsp_pba   <= pick_found ? pick_idx : '0;
          rsp_err   <= !pick_found;
          rsp_erase <= pick_found && pick_erase;
          state     <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a stalled response holds all its fields
  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_pba) &&
                                  $stable(rsp_err) && $stable(rsp_erase));

  // R12: a failed request never asks for an erase and names block 0
  assert_err_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !rsp_erase && rsp_pba == '0);

  // R5: dynamic allocation never requests an erase
  assert_dyn_no_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && !wl_static) |-> !pick_erase);
endmodule

// File: tb/test_flash_wl_alloc.sv
`timescale 1ns/1ps
module test_flash_wl_alloc;
  localparam int P = 8, L = 4, CW = 4, NR = 2;
  localparam int PW = $clog2(P), LW = $clog2(L);
  localparam logic [1:0] OP_RST = 2'd0, OP_MRK = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wl_static = 1'b0, bb_reserve = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1, mark_bad = 1'b0;
  logic [LW-1:0] req_lba = '0;
  logic [PW-1:0] mark_pba = '0;
  logic req_ready, rsp_valid, rsp_erase, rsp_err;
  logic [PW-1:0] rsp_pba;

  flash_wl_alloc #(.NUM_PHYS(P), .NUM_LOG(L), .CNT_W(CW), .NUM_RSV(NR)) i_flash_wl_alloc (
    .clk(clk), .rst_n(rst_n), .wl_static(wl_static), .bb_reserve(bb_reserve),
    .req_valid(req_valid), .req_ready(req_ready), .req_lba(req_lba), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pba(rsp_pba),
    .rsp_erase(rsp_erase), .rsp_err(rsp_err), .mark_bad(mark_bad), .mark_pba(mark_pba)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // vector: {op, static, reserve, addr, exp_pba, exp_erase, exp_err, req}
  function automatic logic [15:0] mk(logic [1:0] op, bit st, bit rv, int a, int p,
                                     bit e, bit x, int rq);
    return {op, st, rv, 3'(a), 3'(p), e, x, 4'(rq)};
  endfunction

  localparam int NV = 33;
  localparam logic [15:0] VEC [NV] = '{
    mk(OP_RST,0,0,0,0,0,0,1),   // R1 reset state
    mk(OP_RD ,0,0,0,0,0,1,4),   // R4 unmapped read
    mk(OP_WR ,0,0,0,0,0,0,5),   // R5 lowest erased
    mk(OP_WR ,0,0,1,1,0,0,5),   // R5
    mk(OP_WR ,0,0,0,2,0,0,8),   // R8 rewrite, block 0 goes stale
    mk(OP_RD ,0,0,0,2,0,0,4),   // R4 mapped read
    mk(OP_WR ,0,0,2,3,0,0,8),   // R8 stale block 0 skipped by dynamic
    mk(OP_MRK,0,0,4,0,0,0,9),   // R9 mark block 4 bad
    mk(OP_WR ,0,0,3,5,0,0,9),   // R9 bad block 4 passed over
    mk(OP_WR ,0,0,3,6,0,0,10),  // R10 single pool
    mk(OP_WR ,0,0,3,7,0,0,10),  // R10 top block used in skip mode
    mk(OP_WR ,0,0,3,0,0,1,12),  // R12 no erased block left
    mk(OP_RD ,0,0,3,7,0,0,12),  // R12 mapping unchanged
    mk(OP_WR ,1,0,3,0,1,0,6),   // R6 stale reuse with erase
    mk(OP_WR ,1,0,3,5,1,0,6),   // R6
    mk(OP_WR ,1,0,3,6,1,0,7),   // R7 count 1 on block 0 loses to 0
    mk(OP_WR ,1,0,3,7,1,0,7),   // R7
    mk(OP_WR ,1,0,3,0,1,0,7),   // R7 all at 1, lowest index
    mk(OP_WR ,1,1,3,5,1,0,11),  // R11 main pool only
    mk(OP_WR ,1,0,3,6,1,0,10),  // R10 spares compete in skip mode
    mk(OP_WR ,1,1,3,0,1,0,11),  // R11 main pool over cheaper spare
    mk(OP_RST,0,0,0,0,0,0,1),   // R1
    mk(OP_RD ,0,0,0,0,0,1,1),   // R1 map cleared
    mk(OP_MRK,0,0,1,0,0,0,9),
    mk(OP_MRK,0,0,2,0,0,0,9),
    mk(OP_MRK,0,0,3,0,0,0,9),
    mk(OP_MRK,0,0,4,0,0,0,9),
    mk(OP_MRK,0,0,6,0,0,0,9),
    mk(OP_WR ,0,1,0,0,0,0,11),  // R11
    mk(OP_WR ,0,1,1,5,0,0,11),  // R11 last main block
    mk(OP_WR ,0,1,2,7,0,0,11),  // R11 spare fallback, bad spare 6 skipped
    mk(OP_WR ,0,1,3,0,0,1,12),  // R12 spares exhausted
    mk(OP_RD ,0,1,3,0,0,1,12)   // R12 still unmapped
  };

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic do_mark(int p);
    mark_bad = 1'b1; mark_pba = PW'(p);
    @(posedge clk); #1;
    mark_bad = 1'b0;
  endtask

  task automatic do_req(bit wr, int lba, output int lat, output int pba,
                        output int er, output int err);
    req_valid = 1'b1; req_write = wr; req_lba = LW'(lba);
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); #1; lat++;
    end
    pba = int'(rsp_pba); er = int'(rsp_erase); err = int'(rsp_err);
    if (rsp_ready) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat, pba, er, err;
    do_reset();
    for (int v = 0; v < NV; v++) begin
      logic [15:0] w;
      string tag;
      w = VEC[v];
      tag = $sformatf("R%0d vec%0d", w[3:0], v);
      wl_static = w[13]; bb_reserve = w[12];
      case (w[15:14])
        OP_RST: begin
          do_reset();
          chk({tag, " ready"}, int'(req_ready), 1);
          chk({tag, " rsp_valid"}, int'(rsp_valid), 0);
        end
        OP_MRK: do_mark(int'(w[11:9]));
        default: begin
          do_req(w[15:14] == OP_WR, int'(w[11:9]), lat, pba, er, err);
          chk({tag, " pba"}, pba, int'(w[8:6]));
          chk({tag, " erase"}, er, int'(w[5]));
          chk({tag, " err"}, err, int'(w[4]));
          // R3 latency in edges after acceptance
          chk({tag, " R3 latency"}, lat, (w[15:14] == OP_WR) ? P + 1 : 0);
        end
      endcase
    end

    // R2: stalled response holds, no new request accepted
    do_reset();
    wl_static = 1'b0; bb_reserve = 1'b0;
    rsp_ready = 1'b0;
    do_req(1'b1, 2, lat, pba, er, err);
    chk("R2 stalled write pba", pba, 0);
    repeat (3) begin
      req_valid = 1'b1; req_write = 1'b0; req_lba = '0;
      @(posedge clk); #1;
      chk("R2 hold valid", int'(rsp_valid), 1);
      chk("R2 hold pba", int'(rsp_pba), 0);
      chk("R2 ready low", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R2 released", int'(rsp_valid), 0);
    chk("R2 idle again", int'(req_ready), 1);
    do_req(1'b1, 3, lat, pba, er, err);
    chk("R2 next write after stall", pba, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule